// File: doc/BRIEF.md
# Dual-Lane Saturating Arithmetic Shifter

This datapath block treats a packed operand as two signed 16-bit lanes and shifts both by one shared signed count. A positive count moves each lane toward the most significant bit. If the true result no longer fits in a signed lane, that lane is clamped to the largest positive or most negative value and its overflow flag is raised. A negative count moves each lane toward the least significant bit, filling from the sign bit. The two lane results are repacked in their original positions.

The count is a 6-bit two's-complement field taken from the bottom of a second input word. All higher bits of that word are ignored. The block has a combinational core. A parameter selects whether an output register is present. With the register present (the default), a valid strobe loads the result and the flags, and a synchronous active-high reset clears them.

Top module: `dual_lane_sat_shifter`

## Requirements
- R1: The operand holds two independent signed lanes: the upper lane in bits 31:16 and the lower lane in bits 15:0. A result in one lane never depends on the other lane, and `lane_ovf[1]` belongs to the upper lane while `lane_ovf[0]` belongs to the lower lane.
- R2: The shift count is `count_word[5:0]`, read as two's complement, giving a range of -32 to +31. Bits 31:6 of `count_word` have no effect; for example, 0x12345678 gives a count of -8.
- R3: A count of zero returns each lane unchanged, with both overflow flags low.
- R4: For a left count n in the range 1 to 15, a lane whose top n+1 bits all equal its sign bit is shifted left with zero fill, and its flag stays low. For example, 0x0123 shifted by 5 gives 0x2460, and 0xFFFF shifted by 15 gives 0x8000.
- R5: For a left count n in the range 1 to 15, a lane whose top n+1 bits are not all equal to its sign bit saturates and raises its flag. A non-negative lane saturates to 0x7FFF and a negative lane saturates to 0x8000. For example, 0x89AB shifted by 4 gives 0x8000.
- R6: For a left count in the range 16 to 31, a zero lane stays 0x0000 with its flag low, and any non-zero lane saturates by sign with its flag raised.
- R7: A negative count -k shifts each lane right by k with sign fill, and both flags stay low. For example, 0x9ABC shifted by -1 gives 0xCD5E.
- R8: For counts from -15 to -32, each lane becomes 0x0000 if it was non-negative and 0xFFFF if it was negative.
- R9: With the output register present, the result and the flags appear one clock after a cycle with `in_valid` high, and `out_valid` is high in that cycle only. Without `in_valid`, the result and the flags keep their last values.
- R10: While `rst` is high at a clock edge, the result, the flags and `out_valid` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and count are valid this cycle |
| operand | input | 32 | Two packed signed 16-bit lanes |
| count_word | input | 32 | Shift count in bits 5:0; all other bits are ignored |
| result | output | 32 | Packed shifted lanes |
| lane_ovf | output | 2 | Per-lane saturation flags (bit 1 is the upper lane) |
| out_valid | output | 1 | The result was loaded in the previous cycle |

## Verification
The assertions check several properties on every cycle:
- A zero count passes the operand straight to the internal lane results.
- A right shift never raises a flag.
- A raised flag always comes with one of the two signed limits.
- A right shift of 15 or more places leaves only sign bits in each lane.
- The register loads, holds and clears as specified.

Some behaviour only the bench's directed scenarios can show: the exact shifted values, the window rule that separates fitting left shifts from saturating ones (0xFFFF by 15 compared with 16), the upper count bits being ignored, and lane independence over a sweep of every count value.

// File: rtl/lsh_pkg.sv
`timescale 1ns/1ps
package lsh_pkg;
  typedef enum logic [1:0] {
    DIR_NONE  = 2'd0,
    DIR_LEFT  = 2'd1,
    DIR_RIGHT = 2'd2
  } shift_dir_e;
endpackage

// File: rtl/lsh_count_decode.sv
`timescale 1ns/1ps
module lsh_count_decode
  import lsh_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] count_field,
  output shift_dir_e       dir,
  output logic [CNT_W-1:0] amount
);
  // Magnitude of a two's-complement count; the most negative value
  // (-2**(CNT_W-1)) still fits as an unsigned CNT_W-bit magnitude.
  function automatic logic [CNT_W-1:0] magnitude(input logic [CNT_W-1:0] c);
    return c[CNT_W-1] ? (~c + 1'b1) : c;
  endfunction

  always_comb begin
    amount = magnitude(count_field);
    if (count_field == '0)        dir = DIR_NONE;
    else if (count_field[CNT_W-1]) dir = DIR_RIGHT;
    else                           dir = DIR_LEFT;
  end
endmodule

// File: rtl/lsh_lane.sv
`timescale 1ns/1ps
module lsh_lane
  import lsh_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic [LANE_W-1:0] lane_in,
  input  shift_dir_e        dir,
  input  logic [CNT_W-1:0]  amount,
  output logic [LANE_W-1:0] lane_out,
  output logic              sat_hit
);
  localparam logic [LANE_W-1:0] POS_LIM = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] NEG_LIM = {1'b1, {(LANE_W-1){1'b0}}};
  localparam int RMAX = LANE_W - 1;

  // Overflow when the top n+1 bits are not all copies of the sign bit;
  // at or beyond the lane width only a zero lane survives.
  function automatic logic left_overflow(input logic [LANE_W-1:0] v,
                                         input logic [CNT_W-1:0]  n);
    logic hit;
    hit = 1'b0;
    if (int'(n) >= LANE_W) return (v != '0);
    for (int i = 0; i < LANE_W; i++) begin
      if ((i >= LANE_W - 1 - int'(n)) && (v[i] != v[LANE_W-1])) hit = 1'b1;
    end
    return hit;
  endfunction

  // Right shifts of RMAX or more all give pure sign fill, so clamp.
  function automatic logic [LANE_W-1:0] right_arith(input logic [LANE_W-1:0] v,
                                                    input logic [CNT_W-1:0]  n);
    int k;
    k = (int'(n) > RMAX) ? RMAX : int'(n);
    return $signed(v) >>> k;
  endfunction

  function automatic logic [LANE_W-1:0] limit_for(input logic [LANE_W-1:0] v);
    return v[LANE_W-1] ? NEG_LIM : POS_LIM;
  endfunction

  logic left_sat;

  always_comb begin
    left_sat = 1'b0;
    sat_hit  = 1'b0;
    lane_out = lane_in;
    case (dir)
      DIR_LEFT: begin
        left_sat = left_overflow(lane_in, amount);
        sat_hit  = left_sat;
        lane_out = left_sat ? limit_for(lane_in) : (lane_in << amount);
      end
      DIR_RIGHT: lane_out = right_arith(lane_in, amount);
      default:   lane_out = lane_in;
    endcase
  end
endmodule

// File: rtl/dual_lane_sat_shifter.sv
`timescale 1ns/1ps
module dual_lane_sat_shifter
  import lsh_pkg::*;
#(
  parameter int LANE_W  = 16,
  parameter int LANES   = 2,
  parameter int CNT_W   = 6,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [LANES*LANE_W-1:0]  operand,
  input  logic [LANES*LANE_W-1:0]  count_word,
  output logic [LANES*LANE_W-1:0]  result,
  output logic [LANES-1:0]         lane_ovf,
  output logic                     out_valid
);
  localparam int DATA_W = LANES * LANE_W;

  shift_dir_e        dir_sel;
  logic [CNT_W-1:0]  dec_amount;
  logic [DATA_W-1:0] lane_next;
  logic [LANES-1:0]  ovf_next;
  logic              unused_count_hi;

  assign unused_count_hi = ^count_word[DATA_W-1:CNT_W];

  lsh_count_decode #(.CNT_W(CNT_W)) u_decode (
    .count_field (count_word[CNT_W-1:0]),
    .dir         (dir_sel),
    .amount      (dec_amount)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lsh_lane #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_lane (
      .lane_in  (operand[g*LANE_W +: LANE_W]),
      .dir      (dir_sel),
      .amount   (dec_amount),
      .lane_out (lane_next[g*LANE_W +: LANE_W]),
      .sat_hit  (ovf_next[g])
    );
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        result    <= '0;
        lane_ovf  <= '0;
        out_valid <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          result   <= lane_next;
          lane_ovf <= ovf_next;
        end
      end
    end
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst;
    assign result    = lane_next;
    assign lane_ovf  = ovf_next;
    assign out_valid = in_valid;
  end
endmodule

// File: rtl/lsh_checker.sv
`timescale 1ns/1ps
module lsh_checker
  import lsh_pkg::*;
#(
  parameter int LANE_W  = 16,
  parameter int LANES   = 2,
  parameter int CNT_W   = 6,
  parameter bit OUT_REG = 1'b1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [LANES*LANE_W-1:0] operand,
  input logic [LANES*LANE_W-1:0] result,
  input logic [LANES-1:0]        lane_ovf,
  input logic                    out_valid,
  input shift_dir_e              dir_sel,
  input logic [CNT_W-1:0]        dec_amount,
  input logic [LANES*LANE_W-1:0] lane_next,
  input logic [LANES-1:0]        ovf_next
);
  localparam logic [LANE_W-1:0] POS_LIM = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] NEG_LIM = {1'b1, {(LANE_W-1){1'b0}}};

  a_r3_zero_passthrough: assert property (@(posedge clk) disable iff (rst)
    (dir_sel == DIR_NONE) |-> (lane_next == operand && ovf_next == '0));

  a_r7_right_no_ovf: assert property (@(posedge clk) disable iff (rst)
    (dir_sel == DIR_RIGHT) |-> (ovf_next == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    a_r5_sat_limits: assert property (@(posedge clk) disable iff (rst)
      ovf_next[g] |-> (lane_next[g*LANE_W +: LANE_W] == POS_LIM ||
                       lane_next[g*LANE_W +: LANE_W] == NEG_LIM));

    a_r8_far_right_sign: assert property (@(posedge clk) disable iff (rst)
      (dir_sel == DIR_RIGHT && int'(dec_amount) >= LANE_W - 1) |->
        (lane_next[g*LANE_W +: LANE_W] == '0 ||
         lane_next[g*LANE_W +: LANE_W] == '1));
  end

  if (OUT_REG) begin : g_reg_chk
    a_r9_capture: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (result == $past(lane_next) && lane_ovf == $past(ovf_next) && out_valid));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(result) && $stable(lane_ovf) && !out_valid));

    a_r10_reset_clear: assert property (@(posedge clk)
      rst |=> (result == '0 && lane_ovf == '0 && !out_valid));
  end
endmodule

bind dual_lane_sat_shifter lsh_checker #(
  .LANE_W(LANE_W), .LANES(LANES), .CNT_W(CNT_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .operand    (operand),
  .result     (result),
  .lane_ovf   (lane_ovf),
  .out_valid  (out_valid),
  .dir_sel    (dir_sel),
  .dec_amount (dec_amount),
  .lane_next  (lane_next),
  .ovf_next   (ovf_next)
);

// File: tb/tb_dual_lane_sat_shifter.sv
`timescale 1ns/1ps
module tb_dual_lane_sat_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [31:0] count_word = '0;
  logic [31:0] result;
  logic [1:0]  lane_ovf;
  logic        out_valid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  dual_lane_sat_shifter dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
    .count_word(count_word), .result(result), .lane_ovf(lane_ovf),
    .out_valid(out_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Reference: exact product / floor division on wide integers, then clamp.
  function automatic logic [16:0] model_lane(input logic [15:0] lane, input logic [5:0] c);
    longint v, p;
    int cnt;
    cnt = c[5] ? int'(c) - 64 : int'(c);
    v = longint'($signed(lane));
    if (cnt >= 0) begin
      p = v * (64'sd1 <<< cnt);
      if (p > 32767)  return {1'b1, 16'h7FFF};
      if (p < -32768) return {1'b1, 16'h8000};
      return {1'b0, p[15:0]};
    end
    if (-cnt >= 16) return {1'b0, (v < 0) ? 16'hFFFF : 16'h0000};
    p = v >>> (-cnt);
    return {1'b0, p[15:0]};
  endfunction

  task automatic apply(input logic [31:0] op, input logic [31:0] cw);
    @(negedge clk);
    operand = op; count_word = cw; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [31:0] op, input logic [31:0] cw,
                            input logic [31:0] exp_res, input logic [1:0] exp_ovf);
    apply(op, cw);
    check(req, result, exp_res);
    check(req, {30'd0, lane_ovf}, {30'd0, exp_ovf});
  endtask

  task automatic t_reset;
    check("R10 reset result", result, 32'h0);
    check("R10 reset flags", {30'd0, lane_ovf}, 32'h0);
    check("R10 reset valid", {31'd0, out_valid}, 32'h0);
  endtask

  task automatic t_zero_count;
    expect_out("R3 zero count", 32'h89AB1234, 32'h0, 32'h89AB1234, 2'b00);
    check("R9 out_valid pulse", {31'd0, out_valid}, 32'h1);
  endtask

  task automatic t_left_fit;
    expect_out("R4 left fit", 32'h01230002, 32'd5, 32'h24600040, 2'b00);
    expect_out("R4 window edge", 32'hC0003FFF, 32'd1, 32'h80007FFE, 2'b00);
    expect_out("R4 neg by 15", 32'h0000FFFF, 32'd15, 32'h00008000, 2'b00);
  endtask

  task automatic t_left_sat;
    expect_out("R5 saturate both", 32'h456789AB, 32'd4, 32'h7FFF8000, 2'b11);
    expect_out("R5 window cross", 32'hC0003FFF, 32'd2, 32'h80007FFF, 2'b11);
  endtask

  task automatic t_big_left;
    expect_out("R6 neg by 16", 32'h0000FFFF, 32'd16, 32'h00008000, 2'b01);
    expect_out("R6 pos by 31", 32'h00010000, 32'd31, 32'h7FFF0000, 2'b10);
  endtask

  task automatic t_right;
    expect_out("R7 right by 1", 32'h56789ABC, 32'h3F, 32'h2B3CCD5E, 2'b00);
    expect_out("R7 right by 8", 32'h23456789, 32'h38, 32'h00230067, 2'b00);
  endtask

  task automatic t_far_right;
    expect_out("R8 right by 15", 32'h456789AB, 32'h31, 32'h0000FFFF, 2'b00);
    expect_out("R8 right by 16", 32'h456789AB, 32'h30, 32'h0000FFFF, 2'b00);
    expect_out("R8 right by 32", 32'h80007FFF, 32'h20, 32'hFFFF0000, 2'b00);
  endtask

  task automatic t_count_field;
    expect_out("R2 upper bits ignored", 32'h23456789, 32'h12345678, 32'h00230067, 2'b00);
    expect_out("R2 low six zero", 32'h89AB1234, 32'hFFFFFFC0, 32'h89AB1234, 2'b00);
    expect_out("R2 field is 6 bits", 32'h01230002, 32'h00000045, 32'h24600040, 2'b00);
  endtask

  task automatic t_hold;
    apply(32'h456789AB, 32'd4);
    operand = 32'h00000001; count_word = 32'd1;
    repeat (3) @(negedge clk);
    check("R9 hold result", result, 32'h7FFF8000);
    check("R9 hold flags", {30'd0, lane_ovf}, 32'h3);
    check("R9 valid low", {31'd0, out_valid}, 32'h0);
  endtask

  task automatic t_lanes;
    logic [31:0] x;
    logic [16:0] hi, lo;
    expect_out("R1 lane independence", 32'h7FFF0001, 32'd1, 32'h7FFF0002, 2'b10);
    x = 32'h1F2E3D4C;
    for (int i = 0; i < 256; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      if (i % 4 == 1) x[15:0] = 16'h0000;
      if (i % 4 == 2) x[31:16] = 16'hFFFF;
      hi = model_lane(x[31:16], 6'(i));
      lo = model_lane(x[15:0], 6'(i));
      expect_out("R1 sweep", x, {x[25:6], 6'(i)}, {hi[15:0], lo[15:0]}, {hi[16], lo[16]});
    end
  endtask

  task automatic t_midreset;
    apply(32'h456789AB, 32'd4);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 mid reset result", result, 32'h0);
    check("R10 mid reset flags", {30'd0, lane_ovf}, 32'h0);
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_zero_count();
    t_left_fit();
    t_left_sat();
    t_big_left();
    t_right();
    t_far_right();
    t_count_field();
    t_hold();
    t_lanes();
    t_midreset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule